// File: doc/BRIEF.md
# Line-Managed Serial Frame Transmitter

This block turns parallel words into asynchronous serial frames on a single three-state pin. A frame is a low start bit, then 8 or 9 data bits least significant bit first, then a high stop bit. The width is picked by a format input. One bit goes out per pulse of an external baud enable. The host writes words into a one-word holding buffer with a write strobe. It watches a buffer-empty flag to know when the next word may be written.

The host also owns two control bits, written together through a control strobe. The first is a transmit enable. Raising it makes the block send a frame-length run of ones. Lowering it lets the frame in flight finish before the pin is released to high impedance. The second is a send-break bit. It produces runs of zeros whose length is always a whole number of frame lengths. Each break is closed by at least one high bit, so that the next start bit can be seen. The output is a data/output-enable pair that an I/O cell combines into the three-state pin.

Top module: `frame_tx`

## Requirements
- R1: After reset the enable and break bits are clear, the output enable is low and the buffer-empty flag is high.
- R2: When the enable bit is written from 0 to 1, the pin starts driving at the next baud pulse and sends 10 ones (format 0) or 11 ones (format 1).
- R3: A frame is a 0 start bit, then the data bits LSB first (8 in format 0, 9 in format 1), then a 1 stop bit, one bit per baud pulse.
- R4: While enabled with nothing pending, the pin is driven high.
- R5: A write while the buffer is empty stores the word and clears the empty flag. The word's move into the shift register at a frame start sets the flag again. A write while the buffer is full is ignored.
- R6: If enable is cleared during a frame, the frame is completed and the output enable then goes low at the frame's end.
- R7: If enable is cleared and set again before the current frame ends, the frame completes and a fresh preamble of ones follows at once.
- R8: A break sends zeros in whole groups of 10 (format 0) or 11 (format 1). A break bit set and cleared between two baud pulses gives exactly one group. A bit held set gives further whole groups until it is seen clear at a group end.
- R9: A break is followed by at least one high bit before any start bit, even when data is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse per serial bit time |
| fmtLong | input | 1 | Frame format: 0 = 8 data bits, 1 = 9 data bits |
| ctrlWr | input | 1 | Strobe that writes the enable and break bits |
| ctrlEn | input | 1 | Enable value written by ctrlWr |
| ctrlBrk | input | 1 | Break value written by ctrlWr |
| wrEn | input | 1 | Buffer write strobe |
| wrData | input | DATA_W | Word to transmit (bit 8 used in format 1 only) |
| bufEmpty | output | 1 | High when the holding buffer can take a word |
| txOe | output | 1 | Output enable for the three-state pin |
| txData | output | 1 | Serial data for the pin |

## Verification
A wrong bit counter or a slipped state decision shows up on txData within one frame length. It appears as a preamble, break or frame that is one bit too long or too short, a missing stop bit, or a start bit right after a break. A lost enable or restart flag shows up as txOe dropping in mid-frame or a missing run of ones, within a single bit time of the frame end. The bench therefore compares the pin bit by bit against an expected stream for every baud period, and tracks the empty flag at each buffer handoff.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PRE,
    ST_IDLE,
    ST_FRAME,
    ST_BRK,
    ST_MARK
  } txState_e;

  typedef struct packed {
    logic load;
    logic shift;
  } dpStrobe_t;

endpackage

// File: rtl/frame_tx_datapath.sv
module frame_tx_datapath
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              fmtLong,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              bufEmpty,
  output logic              serBit
);
  localparam int SH_W = DATA_W + 2;

  logic [DATA_W-1:0] bufReg;
  logic              emptyReg;
  logic [SH_W-1:0]   shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufReg   <= '0;
      emptyReg <= 1'b1;
      shiftReg <= '1;
    end else begin
      if (strb.load) begin
        if (fmtLong) shiftReg <= {1'b1, bufReg, 1'b0};
        else         shiftReg <= {2'b11, bufReg[DATA_W-2:0], 1'b0};
        emptyReg <= 1'b1;
      end else if (strb.shift) begin
        shiftReg <= {1'b1, shiftReg[SH_W-1:1]};
      end
      if (wrEn && emptyReg) begin
        bufReg   <= wrData;
        emptyReg <= 1'b0;
      end
    end
  end

  assign bufEmpty = emptyReg;
  assign serBit   = shiftReg[0];

  a_r5_load_needs_word: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !emptyReg);

  a_r5_write_full_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !emptyReg && !strb.load) |=> $stable(bufReg));

endmodule

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      fmtLong,
  input  logic      ctrlWr,
  input  logic      ctrlEn,
  input  logic      ctrlBrk,
  input  logic      bufEmpty,
  input  logic      serBit,
  output dpStrobe_t strb,
  output logic      txOe,
  output logic      txData
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W);

  txState_e         state, nxt, unitNext;
  logic [CNT_W-1:0] cnt, lastIdx;
  logic             enReg, brkReg, prePend, brkPend;
  logic             unitDone, multiBit;

  assign lastIdx  = fmtLong ? LAST_LONG : LAST_SHORT;
  assign multiBit = (state == ST_PRE) || (state == ST_FRAME) || (state == ST_BRK);
  assign unitDone = baudTick && (!multiBit || (cnt == lastIdx));

  always_comb begin
    if (!enReg)                  unitNext = ST_OFF;
    else if (prePend)            unitNext = ST_PRE;
    else if (brkReg || brkPend)  unitNext = ST_BRK;
    else if (!bufEmpty)          unitNext = ST_FRAME;
    else                         unitNext = ST_IDLE;
  end

  always_comb begin
    nxt = state;
    if (unitDone) begin
      if (state == ST_BRK) nxt = (enReg && brkReg) ? ST_BRK : ST_MARK;
      else                 nxt = unitNext;
    end
  end

  always_comb begin
    strb.load  = unitDone && (nxt == ST_FRAME);
    strb.shift = baudTick && (state == ST_FRAME) && !unitDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_OFF;
      cnt     <= '0;
      enReg   <= 1'b0;
      brkReg  <= 1'b0;
      prePend <= 1'b0;
      brkPend <= 1'b0;
    end else begin
      if (unitDone) begin
        state <= nxt;
        cnt   <= '0;
        if (nxt == ST_PRE) prePend <= 1'b0;
        if (nxt == ST_BRK) brkPend <= 1'b0;
      end else if (baudTick) begin
        cnt <= cnt + 1'b1;
      end
      if (ctrlWr) begin
        enReg  <= ctrlEn;
        brkReg <= ctrlBrk;
        if (ctrlEn && !enReg) prePend <= 1'b1;
        if (ctrlBrk)          brkPend <= 1'b1;
      end
    end
  end

  assign txOe   = (state != ST_OFF);
  assign txData = (state == ST_FRAME) ? serBit : (state != ST_BRK);

  a_r6_release_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txOe) |-> $past(baudTick));

  a_r2_drive_starts_preamble: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txOe) |-> (state == ST_PRE));

  a_r8_whole_break_group: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_BRK && state != ST_BRK) |-> ($past(cnt) == $past(lastIdx)));

  a_r9_high_after_break: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_BRK && state != ST_BRK) |-> txData);

  a_r3_strobes_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load || strb.shift) |-> baudTick);

endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              fmtLong,
  input  logic              ctrlWr,
  input  logic              ctrlEn,
  input  logic              ctrlBrk,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              bufEmpty,
  output logic              txOe,
  output logic              txData
);
  dpStrobe_t strb;
  logic      serBit;

  frame_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .fmtLong(fmtLong),
    .ctrlWr(ctrlWr), .ctrlEn(ctrlEn), .ctrlBrk(ctrlBrk),
    .bufEmpty(bufEmpty), .serBit(serBit), .strb(strb),
    .txOe(txOe), .txData(txData)
  );

  frame_tx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fmtLong(fmtLong),
    .wrEn(wrEn), .wrData(wrData), .bufEmpty(bufEmpty), .serBit(serBit)
  );

endmodule

// File: tb/frame_tx_tb.sv
module frame_tx_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       fmtLong = 1'b0;
  logic       ctrlWr = 1'b0, ctrlEn = 1'b0, ctrlBrk = 1'b0;
  logic       wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic       bufEmpty, txOe, txData;
  logic [1:0] tickCnt = '0;
  logic       enShadow = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  logic [1:0] expQ[$];
  string      tagQ[$];

  frame_tx u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .fmtLong(fmtLong),
    .ctrlWr(ctrlWr), .ctrlEn(ctrlEn), .ctrlBrk(ctrlBrk),
    .wrEn(wrEn), .wrData(wrData), .bufEmpty(bufEmpty),
    .txOe(txOe), .txData(txData)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickCnt  <= tickCnt + 2'd1;
    baudTick <= (tickCnt == 2'd2);
  end

  // Monitor: the last negedge before a baud edge closes one bit period.
  always @(negedge clk) begin
    if (rstN && tickCnt == 2'd2 && expQ.size() > 0) begin
      logic [1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (txOe !== e[1] || (e[1] && txData !== e[0])) begin
        nFails++;
        $display("FAIL %s: pin oe/data=%b/%b expected %b/%b", t, txOe, txData, e[1], e[0]);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pushBit(input logic oe, input logic d, input string tag);
    expQ.push_back({oe, d});
    tagQ.push_back(tag);
  endtask

  task automatic pushRun(input int n, input logic oe, input logic d, input string tag);
    for (int i = 0; i < n; i++) pushBit(oe, d, tag);
  endtask

  task automatic pushFrame(input logic [8:0] w, input logic lng, input string tag);
    pushBit(1'b1, 1'b0, tag);
    for (int i = 0; i < (lng ? 9 : 8); i++) pushBit(1'b1, w[i], tag);
    pushBit(1'b1, 1'b1, tag);
  endtask

  task automatic waitTick();
    @(posedge clk iff baudTick);
    @(negedge clk);
  endtask

  task automatic ctrl(input logic en, input logic brk);
    ctrlWr = 1'b1; ctrlEn = en; ctrlBrk = brk; enShadow = en;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic writeWord(input logic [8:0] w);
    wrEn = 1'b1; wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic drain();
    wait (expQ.size() == 0);
    waitTick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 oe", txOe, 1'b0);
    check("R1 empty", bufEmpty, 1'b1);
    pushRun(3, 1'b0, 1'b1, "R1 stays released");
    drain();

    // R2: preamble in format 0, then R4 idle high
    ctrl(1'b1, 1'b0);
    pushBit(1'b0, 1'b1, "R2 before first tick");
    pushRun(10, 1'b1, 1'b1, "R2 preamble 10");
    pushRun(2, 1'b1, 1'b1, "R4 idle high");
    drain();

    // R3/R5: one frame; second write while full is ignored
    writeWord(9'h0A5);
    check("R5 empty cleared", bufEmpty, 1'b0);
    writeWord(9'h03C);
    pushBit(1'b1, 1'b1, "R4 idle");
    pushFrame(9'h0A5, 1'b0, "R3 frame A5");
    pushRun(2, 1'b1, 1'b1, "R5 no frame from ignored write");
    drain();
    check("R5 empty set after handoff", bufEmpty, 1'b1);

    // R5: back-to-back frames through the buffer
    writeWord(9'h00F);
    pushBit(1'b1, 1'b1, "R4 idle");
    pushFrame(9'h00F, 1'b0, "R5 first of pair");
    pushFrame(9'h0F0, 1'b0, "R5 second of pair");
    pushRun(2, 1'b1, 1'b1, "R4 idle");
    waitTick();
    check("R5 empty after load", bufEmpty, 1'b1);
    writeWord(9'h0F0);
    drain();

    // R3: format 1 frame
    fmtLong = 1'b1;
    writeWord(9'h1AB);
    pushBit(1'b1, 1'b1, "R4 idle");
    pushFrame(9'h1AB, 1'b1, "R3 frame 1AB");
    pushRun(2, 1'b1, 1'b1, "R4 idle");
    drain();

    // R6: disable mid-frame
    writeWord(9'h0C3);
    pushBit(1'b1, 1'b1, "R4 idle");
    pushFrame(9'h0C3, 1'b1, "R6 frame completes");
    pushRun(3, 1'b0, 1'b1, "R6 released after frame");
    waitTick();
    waitTick();
    ctrl(1'b0, 1'b0);
    drain();
    check("R6 oe low", txOe, 1'b0);

    // R2: preamble in format 1
    ctrl(1'b1, 1'b0);
    pushBit(1'b0, 1'b1, "R2 before first tick");
    pushRun(11, 1'b1, 1'b1, "R2 preamble 11");
    pushRun(2, 1'b1, 1'b1, "R4 idle");
    drain();

    // R7: disable and re-enable mid-frame
    writeWord(9'h155);
    pushBit(1'b1, 1'b1, "R4 idle");
    pushFrame(9'h155, 1'b1, "R7 frame completes");
    pushRun(11, 1'b1, 1'b1, "R7 fresh preamble");
    pushRun(2, 1'b1, 1'b1, "R4 idle");
    waitTick();
    waitTick();
    ctrl(1'b0, 1'b0);
    ctrl(1'b1, 1'b0);
    drain();

    // R8/R9: break pulse with data waiting, format 0
    fmtLong = 1'b0;
    ctrl(1'b1, 1'b1);
    ctrl(1'b1, 1'b0);
    writeWord(9'h05A);
    pushBit(1'b1, 1'b1, "R4 idle");
    pushRun(10, 1'b1, 1'b0, "R8 one break group");
    pushBit(1'b1, 1'b1, "R9 high after break");
    pushFrame(9'h05A, 1'b0, "R9 frame after mark");
    pushRun(2, 1'b1, 1'b1, "R4 idle");
    drain();

    // R8: held break spans two whole groups
    ctrl(1'b1, 1'b1);
    pushBit(1'b1, 1'b1, "R4 idle");
    pushRun(20, 1'b1, 1'b0, "R8 two break groups");
    pushBit(1'b1, 1'b1, "R9 high after break");
    pushRun(2, 1'b1, 1'b1, "R4 idle");
    repeat (12) waitTick();
    ctrl(1'b1, 1'b0);
    drain();

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, pending=%0d expected 0", expQ.size());
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule